// File: doc/BRIEF.md
# Time-Shared Bit-Serial Crossbar

This block connects 30 bit-serial PCM inputs to 30 bit-serial outputs. Any output may take its data from any input, and several outputs may share one input. Two shared 30-to-1 multiplexers do all the switching instead of one multiplexer per output. The fabric clock runs 15 times faster than the port bit rate, so one data bit lasts 15 fabric cycles, called slots. In each slot, each shared multiplexer fills one output flip-flop. The first multiplexer serves outputs 0 to 14 and the second serves outputs 15 to 29.

Routes are kept in two small select memories, one for each multiplexer, and the slot number indexes them. A write on the control bus names an output and the input it should carry. The write changes only that output's entry, so every other live route keeps running without a disturbed bit. The inputs are captured once per bit period, at the end of the last slot. All 15 slots of a period therefore switch the same input bits.

Top module: `tdm_xbar`

## Requirements
- R1: With 30 inputs and 30 outputs, output `a` carries the input bit named by its route, or 0 when that route value is 30 or 31. Several outputs may name the same input.
- R2: When `cfg_we_i` is high at a clock edge, the 5-bit `cfg_sel_i` becomes the route of the output whose index is the 5-bit `cfg_addr_i`.
- R3: A control write whose output index is 30 or 31 changes no route and no output.
- R4: An output whose route value is 30 or 31 drives 0.
- R5: While `rst_i` is high every output is 0, and after reset every output routes from input 0.
- R6: An internal slot counter steps from 0 to 14 and then returns to 0, one step per clock. It starts at 0 on the first clock after reset.
- R7: `din_i` is captured only at the edge that ends slot 14. Values it holds in any other cycle have no effect.
- R8: Output `k` of the first group, and output `15+k` of the second group, change only at the edge that ends slot `k`. Writing one output's route never changes any other output.
- R9: Input bits captured at the end of slot 14 appear on every output no later than the next edge that ends slot 14. A route written at the same edge as that capture already applies to those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fabric clock, 15 cycles per port bit |
| rst_i | input | 1 | Synchronous active-high reset |
| din_i | input | 30 | One bit from each serial input port |
| cfg_we_i | input | 1 | Route write strobe |
| cfg_addr_i | input | 5 | Index of the output to reroute |
| cfg_sel_i | input | 5 | Index of the input that output should carry |
| dout_o | output | 30 | One registered bit for each serial output port |

## Verification
The assertions make two assumptions. First, reset is applied before the first useful cycle. Second, `din_i` and the control bus are synchronous to the fabric clock. Within those limits they accept any timing of input changes and of route writes.

The stimulus fills every non-sampled cycle of each bit period with random noise on `din_i`. It places the real bits only in the cycle before the capture edge, so the result depends on capture happening at that edge and nowhere else. Route writes, including the ignored high addresses, are issued on the capture edge, one per period. Each checked period therefore has a single, well-defined routing table.

// File: rtl/tdm_xbar_pkg.sv
`timescale 1ns/1ps
package tdm_xbar_pkg;
  localparam int XBAR_PORTS = 30;
  localparam int XBAR_SLOTS = 15;

  // Number of shared multiplexers needed to cover all outputs.
  function automatic int lanes_for(input int ports, input int slots);
    return (ports + slots - 1) / slots;
  endfunction
endpackage

// File: rtl/tdm_xbar_slot_ctr.sv
`timescale 1ns/1ps
module tdm_xbar_slot_ctr #(
  parameter int SLOTS  = 15,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i)                   slot_o <= '0;
    else if (slot_o == LAST_SLOT) slot_o <= '0;
    else                          slot_o <= slot_o + 1'b1;
  end

  assign last_o = (slot_o == LAST_SLOT);
endmodule

// File: rtl/tdm_xbar_sel_mem.sv
`timescale 1ns/1ps
module tdm_xbar_sel_mem #(
  parameter int LANE_ID = 0,
  parameter int NUM_OUT = 30,
  parameter int SLOTS   = 15,
  parameter int SEL_W   = 5,
  parameter int ADDR_W  = 5,
  parameter int SLOT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [SEL_W-1:0]  rd_sel_o
);
  localparam int DEPTH = 2 ** SLOT_W;
  localparam int BASE  = LANE_ID * SLOTS;

  // The route store has no reset, so it can map onto distributed or block RAM.
  logic [SEL_W-1:0]  route_mem [DEPTH];
  // Per-entry written flag; a cleared flag reads as route 0.
  logic [DEPTH-1:0]  written_q;
  logic              hit;
  logic [SLOT_W-1:0] entry;

  always_comb begin
    hit   = wr_en_i
          && (int'(wr_addr_i) >= BASE)
          && (int'(wr_addr_i) <  BASE + SLOTS)
          && (int'(wr_addr_i) <  NUM_OUT);
    entry = SLOT_W'(int'(wr_addr_i) - BASE);
  end

  always_ff @(posedge clk_i) begin
    if (hit) route_mem[entry] <= wr_sel_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)    written_q <= '0;
    else if (hit) written_q[entry] <= 1'b1;
  end

  assign rd_sel_o = written_q[rd_slot_i] ? route_mem[rd_slot_i] : '0;
endmodule

// File: rtl/tdm_xbar_lane.sv
`timescale 1ns/1ps
module tdm_xbar_lane #(
  parameter int NUM_IN = 30,
  parameter int SLOTS  = 15,
  parameter int SEL_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_IN-1:0] in_vec_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SLOTS-1:0]  out_o
);
  logic pick;

  // Shared wide multiplexer; select values past the last input give 0.
  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (sel_i == SEL_W'(i)) pick = in_vec_i[i];
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_out
    always_ff @(posedge clk_i) begin
      if (rst_i)                         out_o[k] <= 1'b0;
      else if (slot_i == SLOT_W'(k))     out_o[k] <= pick;
    end
  end
endmodule

// File: rtl/tdm_xbar.sv
`timescale 1ns/1ps
module tdm_xbar
  import tdm_xbar_pkg::*;
#(
  parameter int NUM_IN  = XBAR_PORTS,
  parameter int NUM_OUT = XBAR_PORTS,
  parameter int SLOTS   = XBAR_SLOTS,
  parameter int SEL_W   = $clog2(NUM_IN),
  parameter int ADDR_W  = $clog2(NUM_OUT)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_IN-1:0]  din_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  output logic [NUM_OUT-1:0] dout_o
);
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int NUM_LANES = lanes_for(NUM_OUT, SLOTS);

  logic [SLOT_W-1:0]          slot_q;
  logic                       slot_last;
  logic [NUM_IN-1:0]          in_q;
  logic [NUM_LANES*SLOTS-1:0] lane_out;

  tdm_xbar_slot_ctr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .slot_o (slot_q),
    .last_o (slot_last)
  );

  // One capture per bit period keeps all slots of a period consistent.
  always_ff @(posedge clk_i) begin
    if (rst_i)          in_q <= '0;
    else if (slot_last) in_q <= din_i;
  end

  for (genvar h = 0; h < NUM_LANES; h++) begin : g_lane
    logic [SEL_W-1:0] lane_sel;

    tdm_xbar_sel_mem #(
      .LANE_ID (h),
      .NUM_OUT (NUM_OUT),
      .SLOTS   (SLOTS),
      .SEL_W   (SEL_W),
      .ADDR_W  (ADDR_W),
      .SLOT_W  (SLOT_W)
    ) u_mem (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .wr_en_i   (cfg_we_i),
      .wr_addr_i (cfg_addr_i),
      .wr_sel_i  (cfg_sel_i),
      .rd_slot_i (slot_q),
      .rd_sel_o  (lane_sel)
    );

    tdm_xbar_lane #(
      .NUM_IN (NUM_IN),
      .SLOTS  (SLOTS),
      .SEL_W  (SEL_W),
      .SLOT_W (SLOT_W)
    ) u_lane (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .in_vec_i (in_q),
      .sel_i    (lane_sel),
      .slot_i   (slot_q),
      .out_o    (lane_out[h*SLOTS +: SLOTS])
    );
  end

  assign dout_o = lane_out[NUM_OUT-1:0];
endmodule

// File: rtl/tdm_xbar_chk.sv
`timescale 1ns/1ps
module tdm_xbar_chk #(
  parameter int NUM_IN  = 30,
  parameter int NUM_OUT = 30,
  parameter int SLOTS   = 15,
  parameter int SLOT_W  = 4
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [NUM_IN-1:0]  din_i,
  input logic [SLOT_W-1:0]  slot_q,
  input logic [NUM_IN-1:0]  in_q,
  input logic [NUM_OUT-1:0] dout_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(slot_q) < SLOTS); // R6
  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_q == LAST) |=> (slot_q == '0)); // R6
  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1)); // R6
  AST_INPUT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_q != LAST) |=> $stable(in_q)); // R7
  AST_INPUT_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_q == LAST) |=> (in_q == $past(din_i))); // R7

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_hold
    AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (slot_q != SLOT_W'(j % SLOTS)) |=> $stable(dout_o[j])); // R8
  end
endmodule

bind tdm_xbar tdm_xbar_chk #(
  .NUM_IN  (NUM_IN),
  .NUM_OUT (NUM_OUT),
  .SLOTS   (SLOTS),
  .SLOT_W  (SLOT_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .din_i  (din_i),
  .slot_q (slot_q),
  .in_q   (in_q),
  .dout_o (dout_o)
);

// File: tb/tdm_xbar_tb_top.sv
`timescale 1ns/1ps
module tdm_xbar_tb_top;
  localparam int NI = 30;
  localparam int NO = 30;
  localparam int SL = 15;

  typedef struct {
    logic [NO-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst;
  logic [NI-1:0] din;
  logic          cfg_we;
  logic [4:0]    cfg_addr;
  logic [4:0]    cfg_sel;
  logic [NO-1:0] dout;

  item_t sbq[$];
  int    route[NO];
  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  tdm_xbar dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .din_i      (din),
    .cfg_we_i   (cfg_we),
    .cfg_addr_i (cfg_addr),
    .cfg_sel_i  (cfg_sel),
    .dout_o     (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [NO-1:0] act, input logic [NO-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: dout=%h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one bit period. Noise fills every cycle except the one before the
  // capture edge, where the real bits and an optional route write are placed.
  task automatic run_period(input logic [NI-1:0] d, input bit we,
                            input int addr, input int sel, input string tag);
    item_t it;
    din    = NI'($urandom);
    cfg_we = 1'b0;
    repeat (SL - 1) @(negedge clk);
    din      = d;
    cfg_we   = we;
    cfg_addr = addr[4:0];
    cfg_sel  = sel[4:0];
    if (we && addr < NO) route[addr] = sel;
    for (int a = 0; a < NO; a++)
      it.exp[a] = (route[a] < NI) ? d[route[a]] : 1'b0;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Monitor: a period's bits are complete one full period after capture.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cyc >= 2*SL && (cyc % SL) == 0 && sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(dout === it.exp, it.tag, dout, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: dout=%h expected queue empty", dout);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NO; a++) route[a] = 0;
    rst = 1'b1; din = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_sel = '0;
    repeat (5) @(negedge clk);
    check(dout === '0, "R5 outputs cleared in reset", dout, '0);
    rst = 1'b0;
    check(dout === '0, "R5 outputs zero after release", dout, '0);

    // R5: default route is input 0 for every output.
    run_period(30'h0000_0001, 1'b0, 0, 0, "R5 default route one");
    run_period(30'h3FFF_FFFE, 1'b0, 0, 0, "R5 default route zero");

    // R2 and R8: reroute each output in turn; the rest must hold their routes.
    for (int a = 0; a < NO; a++)
      run_period(NI'($urandom), 1'b1, a, (a * 7 + 3) % NI, "R2 R8 reroute");

    // R3: writes to nonexistent outputs leave every route alone.
    run_period(NI'($urandom), 1'b1, 30, 5, "R3 address 30");
    run_period(NI'($urandom), 1'b1, 31, 9, "R3 address 31");

    // R4: routes past the last input drive 0.
    run_period(30'h3FFF_FFFF, 1'b1, 4, 30, "R4 route 30");
    run_period(30'h3FFF_FFFF, 1'b1, 20, 31, "R4 route 31");

    // R1: fan-out of one input to many outputs, plus fixed patterns.
    run_period(30'h2AAA_AAAA, 1'b1, 0, 13, "R1 alternating");
    run_period(30'h1555_5555, 1'b1, 1, 13, "R1 alternating inverse");
    run_period(30'h3FFF_FFFF, 1'b0, 0, 0, "R1 all ones");
    run_period(30'h0000_0000, 1'b0, 0, 0, "R9 all zeros");
    for (int i = 0; i < 4; i++)
      run_period(NI'($urandom), 1'b0, 0, 0, "R7 R6 noise outside capture");

    wait (sbq.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule